// File: doc/BRIEF.md
# Sampled Multi-Size Shadow Tag Profiler

This block watches the stream of last-level cache accesses and estimates, for each core, how many misses that core would suffer at seven cache capacities at once: the full size and each halving down to one sixty-fourth. It keeps no data, only tag arrays, and only for one set in every 2^SAMPLE_W. An access whose set-index sampling bits are all zero enters a short queue. A controller then takes it out and checks it against each emulated size, one size per cycle. Each size that misses bumps the counter for that core and that size.

Software reads any counter through a registered read port. At each interval boundary it pulses `clear` to zero all counters and turns the counts into per-core miss curves for its allocation decisions. The profiler has no handshake back to the cache. When the queue is full it drops the access and counts the drop, so cache traffic never waits on it.

With the default parameters an address is split, from the low end, into a 6-bit block offset, 6 sampling bits, a 6-bit sampled set index and a 24-bit tag. Each emulated set is 4-way with true LRU replacement.

Top module: `shadow_tag_profiler`

## Requirements
- R1: After reset and the start-up sweep of NUM_CORES*2^SAMP_SET_W cycles, every miss counter and the drop count read zero and every emulated line is invalid, so the first access to any set misses at all seven sizes.
- R2: An access whose address bits [OFF_W+SAMPLE_W-1:OFF_W] are not all zero is ignored. It changes no miss counter and no drop count.
- R3: Size k (0 = full, 6 = 1/64) indexes its sets with the sampled set index (address bits just above the sampling bits) after dropping the index's top k bits. A line matches only if its stored tag and full sampled index both equal the access's, so two addresses that differ only in dropped index bits compete for the same set.
- R4: An access to a line that is present at a size counts no miss at that size.
- R5: Each emulated set holds WAYS lines with true LRU. A hit makes the line most recent. A miss replaces the least recently used line and adds one to the miss counter for that core and size.
- R6: Each core has its own emulated arrays and counters. An access from one core never changes another core's lines or counts.
- R7: `rd_data` shows the counter selected by `rd_core`/`rd_size` one clock after they are applied. It shows zero for a core or size index out of range.
- R8: A one-cycle `clear` sets all miss counters and the drop count to zero on the next clock, while emulated tags are kept.
- R9: Sampled accesses wait in a QDEPTH-entry queue. One arriving while the queue holds QDEPTH entries is discarded and raises `drop_count` by one. Each accepted access is profiled exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_core | input | CORE_W | Core issuing the access |
| acc_addr | input | ADDR_W | Physical byte address of the access |
| clear | input | 1 | Interval-boundary pulse zeroing all counters |
| rd_core | input | CORE_W | Core selecting the counter to read |
| rd_size | input | SIZE_W | Size selecting the counter to read (0 = full) |
| rd_data | output | CNT_W | Selected miss counter, registered |
| drop_count | output | CNT_W | Sampled accesses discarded on a full queue |

## Verification
The assertions assume `acc_core` stays below NUM_CORES and that `clear` is not asserted while the bench still expects a count to be retained. They also assume nothing about `acc_addr` beyond its width, so unsampled addresses are legal inputs.

The stimulus sends only valid core numbers. It spaces single accesses far enough apart that each is fully profiled before the counters are read. It creates a full queue only in one deliberate back-to-back burst. That burst's result is checked as a conservation law (drops plus misses equal accesses) rather than a cycle-exact drop pattern.

// File: rtl/tagprof_pkg.sv
package tagprof_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_RUN  = 2'd2
  } prof_state_t;
endpackage

// File: rtl/tagprof_fifo.sv
module tagprof_fifo #(
  parameter int W      = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int QC_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push_req,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic [QC_W-1:0]  count,
  output logic [CNT_W-1:0] drop_count
);
  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             accept, take;

  assign empty  = (count == '0);
  assign full   = (count == QC_W'(DEPTH));
  assign accept = push_req && !full;
  assign take   = pop && !empty;
  assign head   = slot_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (accept) slot_q[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (take)   rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + QC_W'(accept) - QC_W'(take);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear)         drop_count <= '0;
    else if (push_req && full) drop_count <= drop_count + 1'b1;
  end
endmodule

// File: rtl/tagprof_size_unit.sv
module tagprof_size_unit #(
  parameter int ROWS   = 128,
  parameter int WAYS   = 4,
  parameter int KEY_W  = 30,
  parameter int CORE_W = 1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int ENT_W = 1 + KEY_W + AGE_W,
  localparam int LINE_W = WAYS * ENT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_we,
  input  logic [ROW_W-1:0]  init_row,
  input  logic              lk_valid,
  input  logic [ROW_W-1:0]  lk_row,
  input  logic [KEY_W-1:0]  lk_key,
  input  logic [CORE_W-1:0] lk_core,
  output logic              miss_o,
  output logic [CORE_W-1:0] miss_core_o
);
  logic [LINE_W-1:0] mem [ROWS];
  logic [LINE_W-1:0] line_q;
  logic              s1_valid;
  logic [ROW_W-1:0]  s1_row;
  logic [KEY_W-1:0]  s1_key;
  logic [CORE_W-1:0] s1_core;

  logic [WAYS-1:0]   v_w;
  logic [KEY_W-1:0]  k_w [WAYS];
  logic [AGE_W-1:0]  a_w [WAYS];
  logic              hit;
  logic [AGE_W-1:0]  hit_way, victim, use_way, use_age;
  logic [LINE_W-1:0] new_line, init_line;

  // Read stage: one set read per lookup.
  always_ff @(posedge clk) begin
    if (lk_valid) line_q <= mem[lk_row];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_row   <= '0;
      s1_key   <= '0;
      s1_core  <= '0;
    end else begin
      s1_valid <= lk_valid;
      s1_row   <= lk_row;
      s1_key   <= lk_key;
      s1_core  <= lk_core;
    end
  end

  // Compare and LRU update stage.
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    victim  = '0;
    for (int w = 0; w < WAYS; w++) begin
      {v_w[w], k_w[w], a_w[w]} = line_q[w*ENT_W +: ENT_W];
    end
    for (int w = 0; w < WAYS; w++) begin
      if (v_w[w] && (k_w[w] == s1_key)) begin
        hit     = 1'b1;
        hit_way = AGE_W'(w);
      end
      if (a_w[w] == AGE_W'(WAYS - 1)) victim = AGE_W'(w);
    end
    use_way = hit ? hit_way : victim;
    use_age = a_w[use_way];
    for (int w = 0; w < WAYS; w++) begin
      if (AGE_W'(w) == use_way)
        new_line[w*ENT_W +: ENT_W] = {1'b1, s1_key, {AGE_W{1'b0}}};
      else if (a_w[w] < use_age)
        new_line[w*ENT_W +: ENT_W] = {v_w[w], k_w[w], a_w[w] + 1'b1};
      else
        new_line[w*ENT_W +: ENT_W] = {v_w[w], k_w[w], a_w[w]};
    end
  end

  // Invalid line with ages forming a permutation, so invalid ways leave first.
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      init_line[w*ENT_W +: ENT_W] = {1'b0, {KEY_W{1'b0}}, AGE_W'(w)};
    end
  end

  always_ff @(posedge clk) begin
    if (init_we)       mem[init_row] <= init_line;
    else if (s1_valid) mem[s1_row]   <= new_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_o      <= 1'b0;
      miss_core_o <= '0;
    end else begin
      miss_o      <= s1_valid && !hit;
      miss_core_o <= s1_core;
    end
  end
endmodule

// File: rtl/tagprof_counters.sv
module tagprof_counters #(
  parameter int NUM_CORES = 2,
  parameter int NUM_SIZES = 7,
  parameter int CORE_W    = 1,
  parameter int SIZE_W    = 3,
  parameter int CNT_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clear,
  input  logic [NUM_SIZES-1:0]              miss_vec,
  input  logic [NUM_SIZES-1:0][CORE_W-1:0]  miss_core,
  input  logic [CORE_W-1:0]                 rd_core,
  input  logic [SIZE_W-1:0]                 rd_size,
  output logic [CNT_W-1:0]                  rd_data
);
  localparam int NCNT = NUM_CORES * NUM_SIZES;
  logic [CNT_W-1:0] cnt_q [NCNT];

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int s = 0; s < NUM_SIZES; s++) begin
        if (rst || clear)
          cnt_q[c*NUM_SIZES+s] <= '0;
        else if (miss_vec[s] && (int'(miss_core[s]) == c))
          cnt_q[c*NUM_SIZES+s] <= cnt_q[c*NUM_SIZES+s] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if ((int'(rd_core) < NUM_CORES) && (int'(rd_size) < NUM_SIZES))
      rd_data <= cnt_q[int'(rd_core)*NUM_SIZES + int'(rd_size)];
    else
      rd_data <= '0;
  end
endmodule

// File: rtl/shadow_tag_profiler.sv
module shadow_tag_profiler
  import tagprof_pkg::*;
#(
  parameter int NUM_CORES  = 2,
  parameter int NUM_SIZES  = 7,
  parameter int WAYS       = 4,
  parameter int ADDR_W     = 42,
  parameter int OFF_W      = 6,
  parameter int SAMPLE_W   = 6,
  parameter int SAMP_SET_W = 6,
  parameter int QDEPTH     = 4,
  parameter int CNT_W      = 32,
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SIZE_W    = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [CORE_W-1:0] acc_core,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              clear,
  input  logic [CORE_W-1:0] rd_core,
  input  logic [SIZE_W-1:0] rd_size,
  output logic [CNT_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int SAMP_SETS = 1 << SAMP_SET_W;
  localparam int KEY_W     = ADDR_W - OFF_W - SAMPLE_W;
  localparam int ENTRY_W   = CORE_W + KEY_W;
  localparam int INIT_ROWS = NUM_CORES * SAMP_SETS;
  localparam int INIT_W    = $clog2(INIT_ROWS + 1);
  localparam int QC_W      = $clog2(QDEPTH + 1);

  logic                sampled, q_push, q_pop, q_empty, q_full;
  logic [QC_W-1:0]     q_count;
  logic [ENTRY_W-1:0]  q_head;
  logic                unused_bits;

  prof_state_t         state;
  logic [INIT_W-1:0]   init_cnt;
  logic [SIZE_W-1:0]   step;
  logic [CORE_W-1:0]   cur_core;
  logic [KEY_W-1:0]    cur_key;
  logic [SAMP_SET_W-1:0] cur_set;
  logic                last_step;

  logic [NUM_SIZES-1:0]             lk_valid;
  logic [NUM_SIZES-1:0]             miss_vec;
  logic [NUM_SIZES-1:0][CORE_W-1:0] miss_core;

  assign unused_bits = ^acc_addr[OFF_W-1:0];
  assign sampled     = (acc_addr[OFF_W +: SAMPLE_W] == '0);
  assign q_push      = acc_valid && sampled;

  tagprof_fifo #(
    .W(ENTRY_W), .DEPTH(QDEPTH), .CNT_W(CNT_W)
  ) u_queue (
    .clk(clk), .rst(rst), .clear(clear),
    .push_req(q_push), .push_data({acc_core, acc_addr[ADDR_W-1 -: KEY_W]}),
    .pop(q_pop), .head(q_head), .empty(q_empty), .full(q_full),
    .count(q_count), .drop_count(drop_count)
  );

  assign last_step = (step == SIZE_W'(NUM_SIZES - 1));
  assign q_pop = !q_empty && ((state == ST_IDLE) || ((state == ST_RUN) && last_step));
  assign cur_set = cur_key[SAMP_SET_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_INIT;
      init_cnt <= '0;
      step     <= '0;
      cur_core <= '0;
      cur_key  <= '0;
    end else begin
      case (state)
        ST_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == INIT_W'(INIT_ROWS - 1)) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (!q_empty) begin
            {cur_core, cur_key} <= q_head;
            step  <= '0;
            state <= ST_RUN;
          end
        end
        default: begin
          if (last_step) begin
            step <= '0;
            if (!q_empty) {cur_core, cur_key} <= q_head;
            else          state <= ST_IDLE;
          end else begin
            step <= step + 1'b1;
          end
        end
      endcase
    end
  end

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int SETS_K = SAMP_SETS >> k;
    localparam int ROWS_K = NUM_CORES * SETS_K;
    localparam int RW_K   = (ROWS_K > 1) ? $clog2(ROWS_K) : 1;
    logic [RW_K-1:0] row_k, irow_k;
    logic            iwe_k;

    assign lk_valid[k] = (state == ST_RUN) && (step == SIZE_W'(k));
    assign row_k  = RW_K'(int'(cur_core) * SETS_K + (int'(cur_set) % SETS_K));
    assign iwe_k  = (state == ST_INIT) && (int'(init_cnt) < ROWS_K);
    assign irow_k = RW_K'(init_cnt);

    tagprof_size_unit #(
      .ROWS(ROWS_K), .WAYS(WAYS), .KEY_W(KEY_W), .CORE_W(CORE_W)
    ) u_unit (
      .clk(clk), .rst(rst),
      .init_we(iwe_k), .init_row(irow_k),
      .lk_valid(lk_valid[k]), .lk_row(row_k), .lk_key(cur_key), .lk_core(cur_core),
      .miss_o(miss_vec[k]), .miss_core_o(miss_core[k])
    );
  end

  tagprof_counters #(
    .NUM_CORES(NUM_CORES), .NUM_SIZES(NUM_SIZES), .CORE_W(CORE_W),
    .SIZE_W(SIZE_W), .CNT_W(CNT_W)
  ) u_counters (
    .clk(clk), .rst(rst), .clear(clear),
    .miss_vec(miss_vec), .miss_core(miss_core),
    .rd_core(rd_core), .rd_size(rd_size), .rd_data(rd_data)
  );
endmodule

// File: rtl/tagprof_checker.sv
module tagprof_checker #(
  parameter int NUM_SIZES = 7,
  parameter int ADDR_W    = 42,
  parameter int OFF_W     = 6,
  parameter int SAMPLE_W  = 6,
  parameter int QDEPTH    = 4,
  parameter int CNT_W     = 32,
  parameter int QC_W      = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 acc_valid,
  input logic [ADDR_W-1:0]    acc_addr,
  input logic                 clear,
  input logic                 q_pop,
  input logic                 q_full,
  input logic [QC_W-1:0]      q_count,
  input logic [NUM_SIZES-1:0] lk_valid,
  input logic [CNT_W-1:0]     drop_count
);
  logic smp;
  assign smp = (acc_addr[OFF_W +: SAMPLE_W] == '0);

  // R2: an unsampled access never grows the queue
  p_unsampled_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !smp && !q_pop) |=> (q_count <= $past(q_count)));

  // R3: the sizes are looked up one at a time
  p_one_size_per_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_valid));

  // R9: queue occupancy bounded
  p_queue_bound_r9: assert property (@(posedge clk) disable iff (rst)
    q_count <= QC_W'(QDEPTH));

  // R9: a drop happens exactly for a sampled arrival on a full queue
  p_drop_on_full_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && smp && q_full && !clear) |=> (drop_count == $past(drop_count) + 1'b1));

  p_no_spurious_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (!(acc_valid && smp && q_full) && !clear) |=> $stable(drop_count));

  // R8: clear empties the drop count
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (drop_count == '0));
endmodule

bind shadow_tag_profiler tagprof_checker #(
  .NUM_SIZES(NUM_SIZES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SAMPLE_W(SAMPLE_W),
  .QDEPTH(QDEPTH), .CNT_W(CNT_W), .QC_W(QC_W)
) u_checker (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr), .clear(clear),
  .q_pop(q_pop), .q_full(q_full), .q_count(q_count), .lk_valid(lk_valid),
  .drop_count(drop_count)
);

// File: tb/tb_shadow_tag_profiler.sv
module tb_shadow_tag_profiler;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [0:0]  acc_core = '0;
  logic [41:0] acc_addr = '0;
  logic        clear = 1'b0;
  logic [0:0]  rd_core = '0;
  logic [2:0]  rd_size = '0;
  logic [31:0] rd_data, drop_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int exp_cnt [2][7];

  always #2.5 clk = ~clk;

  shadow_tag_profiler dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_core(acc_core),
    .acc_addr(acc_addr), .clear(clear), .rd_core(rd_core), .rd_size(rd_size),
    .rd_data(rd_data), .drop_count(drop_count)
  );

  // Vector table: core, tag, sampled set, expected miss bits per size (bit k = size k)
  localparam int          V_CORE [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam int          V_TAG  [NV] = '{1, 1, 1, 1, 1, 2, 3, 1, 1, 1, 1, 1};
  localparam int          V_SET  [NV] = '{0, 0, 32, 0, 1, 0, 0, 32, 0, 1, 0, 0};
  localparam logic [6:0]  V_MISS [NV] = '{
    7'h7F,  // R1 cold miss everywhere
    7'h00,  // R4 repeat hits
    7'h7F,  // R3 top index bit differs: alias but distinct key
    7'h00,  // R4
    7'h7F,  // R3 new set at sizes 0..5, new key at size 6
    7'h7F,  // R5 fills
    7'h7F,  // R5 size 6 evicts its LRU line
    7'h40,  // R5 only the single-set size lost this line
    7'h40,  // R5
    7'h40,  // R5
    7'h7F,  // R6 other core starts cold
    7'h00   // R6
  };

  function automatic logic [41:0] mk_addr(int tag, int set, int smp);
    return {24'(tag), 6'(set), 6'(smp), 6'h0};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(int core, logic [41:0] addr);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_core  = 1'(core);
    acc_addr  = addr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic read_cnt(int core, int size, output int val);
    @(negedge clk);
    rd_core = 1'(core);
    rd_size = 3'(size);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_core(int core, string req);
    int v;
    for (int s = 0; s < 7; s++) begin
      read_cnt(core, s, v);
      check(v == exp_cnt[core][s], req, v, exp_cnt[core][s]);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 7; s++) exp_cnt[c][s] = 0;
  endtask

  initial begin
    int v, m, d;
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 7; s++) exp_cnt[c][s] = 0;
    wait_cycles(4);
    rst = 1'b0;
    wait_cycles(200);

    // R1: reset state
    check(drop_count == 0, "R1 drop", int'(drop_count), 0);
    check_core(0, "R1 counters core0");
    check_core(1, "R1 counters core1");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      access(V_CORE[i], mk_addr(V_TAG[i], V_SET[i], 0));
      wait_cycles(20);
      for (int s = 0; s < 7; s++)
        if (V_MISS[i][s]) exp_cnt[V_CORE[i]][s]++;
      check_core(V_CORE[i], $sformatf("R3/R4/R5/R6 vector %0d", i));
    end
    check_core(0, "R6 core0 unaffected by core1");

    // R2: unsampled accesses ignored
    access(0, mk_addr(7, 3, 1));
    access(0, mk_addr(8, 0, 32));
    wait_cycles(20);
    check_core(0, "R2 unsampled");
    check(drop_count == 0, "R2 drop", int'(drop_count), 0);

    // R7: latency and out-of-range
    @(negedge clk);
    rd_core = 1'b0; rd_size = 3'd6;
    @(negedge clk);
    check(rd_data == 32'd8, "R7 one-cycle read", int'(rd_data), 8);
    rd_size = 3'd7;
    @(negedge clk);
    check(rd_data == 32'd0, "R7 out of range", int'(rd_data), 0);

    // R8: clear keeps tags but zeroes counts
    pulse_clear();
    check_core(0, "R8 clear core0");
    check_core(1, "R8 clear core1");
    access(0, mk_addr(1, 0, 0));
    wait_cycles(20);
    exp_cnt[0][6] = 0;
    check_core(0, "R8 tags kept over clear");

    // R9: back-to-back burst overflows the queue
    pulse_clear();
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      acc_valid = 1'b1;
      acc_core  = 1'b1;
      acc_addr  = mk_addr(100 + i, 5, 0);
      @(negedge clk);
    end
    acc_valid = 1'b0;
    wait_cycles(150);
    read_cnt(1, 0, m);
    d = int'(drop_count);
    check(m + d == 12, "R9 drops+misses", m + d, 12);
    check(d >= 1, "R9 some drop", d, 1);
    check(d <= 12 - 5, "R9 queue absorbed", d, 7);

    pulse_clear();
    check(drop_count == 0, "R8 drop clear", int'(drop_count), 0);
    read_cnt(1, 0, v);
    check(v == 0, "R8 counter clear", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule